// File: doc/BRIEF.md
# Class-D Bridge Protection Supervisor

This block supervises a bridge-tied audio power stage. It watches four conditions: the differential PWM duty cycle reported by a duty estimator, a short-circuit comparator flag, a die temperature code, and an active-low standby request. From these it drives a bridge enable, where low puts the bridge outputs in Hi-Z. It also drives an active-low alarm meant for an open-drain pin.

Each protection has its own set and clear rule.

- **DC offset:** a persistent offset at one polarity trips a DC lock. Only a power-on reset releases it.
- **Short circuit:** a short sets a latch. Any period with standby low clears it, so tying the alarm back to the standby input gives automatic recovery.
- **Over-temperature:** this shutdown is not latched and releases with hysteresis. It never touches the alarm.

While standby is low, the bridge is off and the DC persistence timer is held at zero, so unsettled inputs cannot cause a false trip. The short and standby inputs pass through a two-stage synchronizer. The duty and temperature codes are registered once. Both outputs are registered.

Top module: `clsd_guard`

## Requirements
- R1: `duty_diff` is a two's complement excursion of the differential duty from 50 %, in percent. A value whose magnitude is strictly above `DC_LIM_PCT` (14) is an excursion, and a magnitude equal to the limit is not. If more than `DC_HOLD_TICKS` consecutive samples are excursions of the same sign, the DC lock sets. `bridge_en` and `alarm_n` go low `DC_HOLD_TICKS`+3 cycles after the first such sample is applied, and are still high one cycle earlier.
- R2: The persistence count restarts when a sample is not an excursion, and when the sign of the excursion changes.
- R3: Only `por` clears the DC lock. Taking `standby_n` low and back high leaves `bridge_en` and `alarm_n` low.
- R4: A high `short_det` sets the short latch. `alarm_n` and `bridge_en` go low 4 cycles after the input rises, and stay low after the flag drops.
- R5: When `standby_n` goes low, the short latch clears and `alarm_n` rises 4 cycles later. While standby is low, clearing takes priority over a present short.
- R6: With `alarm_n` wired to `standby_n`, a short-circuit pulse pulls the alarm low. The bridge then recovers on its own, with both outputs high again within 20 cycles.
- R7: `temp_c` is unsigned degrees C. A value above `TEMP_TRIP` (150) turns `bridge_en` off 3 cycles later. A value of exactly 150 does not.
- R8: The thermal shutdown releases only when `temp_c` is at or below `TEMP_TRIP`-`TEMP_HYST` (135), and `bridge_en` returns 3 cycles later. Values from 136 to 150 keep it off.
- R9: The thermal shutdown never drives `alarm_n` low.
- R10: `standby_n` low turns `bridge_en` off 3 cycles later. While standby is low, the DC persistence count is held at zero.
- R11: While `por` is high, `bridge_en` is 0 and `alarm_n` is 1. After release with standby high, `bridge_en` rises 3 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| standby_n | input | 1 | Active-low standby request, asynchronous |
| duty_diff | input | DUTY_W | Signed differential duty excursion, percent |
| short_det | input | 1 | Short-circuit comparator flag, asynchronous |
| temp_c | input | TEMP_W | Die temperature, unsigned degrees C |
| bridge_en | output | 1 | Bridge output enable, low = Hi-Z |
| alarm_n | output | 1 | Active-low fault alarm (DC lock or short latch) |

## Verification
Each result has a fixed latency from the negedge where its input is driven:

| Input path | Outputs affected | Latency |
|---|---|---|
| Short flag and standby (synchronizer, latch, output register) | Outputs | 4 edges |
| Standby to enable | `bridge_en` | 3 edges |
| Temperature (input register, thermal state, output register) | `bridge_en` | 3 edges |
| Persistent DC excursion | Outputs | `DC_HOLD_TICKS`+3 edges |

The driver turns each stimulus into expected output pairs tagged with their due cycle. The monitor compares each pair on the falling edge of exactly that cycle. Each boundary is checked on both sides: one cycle before the change is due and in the cycle it is due.

// File: rtl/clsd_pkg.sv
package clsd_pkg;

  typedef struct packed {
    logic dc_lock;
    logic sc_lock;
    logic hot;
  } guard_flags_t;

  function automatic logic any_alarm(guard_flags_t f);
    return f.dc_lock | f.sc_lock;
  endfunction

  function automatic logic may_drive(guard_flags_t f, logic awake);
    return awake & ~f.dc_lock & ~f.sc_lock & ~f.hot;
  endfunction

endpackage

// File: rtl/clsd_sync.sv
module clsd_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/clsd_dc_watch.sv
module clsd_dc_watch #(
  parameter int DUTY_W  = 8,
  parameter int DC_LIM  = 14,
  parameter int DC_HOLD = 4200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [DUTY_W-1:0] duty_in,
  output logic              dc_lock
);
  localparam int CNT_W = $clog2(DC_HOLD + 2);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(DC_HOLD);
  localparam logic [CNT_W-1:0] TOP_C  = CNT_W'(DC_HOLD + 1);
  localparam int signed LIM_S = DC_LIM;

  logic signed [DUTY_W-1:0] duty_r;
  logic [CNT_W-1:0]         cnt, cnt_nxt;
  logic                     sign_r;
  logic                     excur, sign_now;

  always_ff @(posedge clk) begin
    if (rst) duty_r <= '0;
    else     duty_r <= duty_in;
  end

  assign sign_now = duty_r[DUTY_W-1];
  assign excur    = (int'(duty_r) > LIM_S) || (int'(duty_r) < -LIM_S);

  always_comb begin
    if (!arm || !excur)                      cnt_nxt = '0;
    else if (cnt != '0 && sign_now != sign_r) cnt_nxt = CNT_W'(1);
    else if (cnt == TOP_C)                   cnt_nxt = TOP_C;
    else                                     cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sign_r  <= 1'b0;
      dc_lock <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      sign_r <= sign_now;
      if (cnt_nxt > HOLD_C) dc_lock <= 1'b1;
    end
  end

  assert_dc_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    dc_lock |=> dc_lock);
  assert_dc_gated_R10: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (cnt == '0));
endmodule

// File: rtl/clsd_short_latch.sv
module clsd_short_latch (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic clear_n,
  output logic sc_lock
);
  always_ff @(posedge clk) begin
    if (rst)           sc_lock <= 1'b0;
    else if (!clear_n) sc_lock <= 1'b0;
    else if (trip)     sc_lock <= 1'b1;
  end

  assert_sc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> !sc_lock);
  assert_sc_set_R4: assert property (@(posedge clk) disable iff (rst)
    (trip && clear_n) |=> sc_lock);
endmodule

// File: rtl/clsd_therm.sv
module clsd_therm #(
  parameter int TEMP_W    = 8,
  parameter int TEMP_TRIP = 150,
  parameter int TEMP_HYST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              hot
);
  localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(TEMP_TRIP);
  localparam logic [TEMP_W-1:0] REL_C  = TEMP_W'(TEMP_TRIP - TEMP_HYST);

  logic [TEMP_W-1:0] temp_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_r <= '0;
      hot    <= 1'b0;
    end else begin
      temp_r <= temp_in;
      if (temp_r > TRIP_C)       hot <= 1'b1;
      else if (temp_r <= REL_C)  hot <= 1'b0;
    end
  end

  assert_hot_trip_R7: assert property (@(posedge clk) disable iff (rst)
    (temp_r > TRIP_C) |=> hot);
  assert_hot_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (hot && temp_r > REL_C) |=> hot);
endmodule

// File: rtl/clsd_guard.sv
module clsd_guard
  import clsd_pkg::*;
#(
  parameter int DUTY_W        = 8,
  parameter int DC_LIM_PCT    = 14,
  parameter int DC_HOLD_TICKS = 4200000,
  parameter int TEMP_W        = 8,
  parameter int TEMP_TRIP     = 150,
  parameter int TEMP_HYST     = 15,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              standby_n,
  input  logic [DUTY_W-1:0] duty_diff,
  input  logic              short_det,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              bridge_en,
  output logic              alarm_n
);
  localparam int FLAG_W = 2;

  logic [FLAG_W-1:0] raw_flags, sync_flags;
  logic              awake, short_s;
  guard_flags_t      flags;

  assign raw_flags = {standby_n, short_det};
  assign awake     = sync_flags[1];
  assign short_s   = sync_flags[0];

  clsd_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk (clk), .rst (por), .d (raw_flags), .q (sync_flags)
  );

  clsd_dc_watch #(.DUTY_W(DUTY_W), .DC_LIM(DC_LIM_PCT), .DC_HOLD(DC_HOLD_TICKS)) u_dc (
    .clk (clk), .rst (por), .arm (awake), .duty_in (duty_diff), .dc_lock (flags.dc_lock)
  );

  clsd_short_latch u_sc (
    .clk (clk), .rst (por), .trip (short_s), .clear_n (awake), .sc_lock (flags.sc_lock)
  );

  clsd_therm #(.TEMP_W(TEMP_W), .TEMP_TRIP(TEMP_TRIP), .TEMP_HYST(TEMP_HYST)) u_th (
    .clk (clk), .rst (por), .temp_in (temp_c), .hot (flags.hot)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      bridge_en <= 1'b0;
      alarm_n   <= 1'b1;
    end else begin
      bridge_en <= may_drive(flags, awake);
      alarm_n   <= ~any_alarm(flags);
    end
  end

  assert_alarm_src_R9: assert property (@(posedge clk) disable iff (por)
    (!flags.dc_lock && !flags.sc_lock) |=> alarm_n);
  assert_standby_off_R10: assert property (@(posedge clk) disable iff (por)
    !awake |=> !bridge_en);
  assert_hot_off_R7: assert property (@(posedge clk) disable iff (por)
    flags.hot |=> !bridge_en);
endmodule

// File: tb/clsd_guard_bench.sv
module clsd_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       sb_drv = 1'b1;
  logic       loop_mode = 1'b0;
  logic [7:0] duty = '0;
  logic       short_det = 1'b0;
  logic [7:0] temp = 8'd25;
  logic       standby_n, bridge_en, alarm_n;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    en;
    bit    al;
    string req;
  } exp_t;
  exp_t q[$];

  assign standby_n = loop_mode ? alarm_n : sb_drv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clsd_guard #(.DC_HOLD_TICKS(H)) u_clsd_guard (
    .clk (clk), .por (por), .standby_n (standby_n), .duty_diff (duty),
    .short_det (short_det), .temp_c (temp), .bridge_en (bridge_en), .alarm_n (alarm_n)
  );

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (bridge_en !== e.en || alarm_n !== e.al) begin
        n_bad++;
        $display("FAIL %s cycle %0d: en=%b alarm_n=%b expected en=%b alarm_n=%b",
                 e.req, cyc, bridge_en, alarm_n, e.en, e.al);
      end
    end
  end

  task automatic expect_at(int lat, bit en, bit al, string req);
    q.push_back('{cyc + lat, en, al, req});
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por_pulse();
    duty = '0; short_det = 1'b0; sb_drv = 1'b1;
    por = 1'b1; tick(2);
    por = 1'b0;
    expect_at(4, 1, 1, "R3");
    tick(6);
  endtask

  initial begin
    tick(1);
    expect_at(1, 0, 1, "R11");
    tick(3);
    por = 1'b0;
    expect_at(2, 0, 1, "R11");
    expect_at(3, 1, 1, "R11");
    tick(5);

    // R1 positive excursion trips after H+3
    duty = 8'sd20;
    expect_at(H + 2, 1, 1, "R1");
    expect_at(H + 3, 0, 0, "R1");
    tick(H + 6);
    // R3 standby toggle does not clear DC lock
    sb_drv = 1'b0; tick(5);
    sb_drv = 1'b1;
    expect_at(6, 0, 0, "R3");
    tick(8);
    por_pulse();

    // R2 polarity change restarts count
    duty = 8'sd20; tick(H);
    duty = -8'sd20; tick(H);
    duty = '0;
    expect_at(3, 1, 1, "R2");
    tick(4);
    // R2 drop below threshold restarts count
    duty = 8'sd20; tick(H);
    duty = '0; tick(1);
    duty = 8'sd20; tick(H);
    duty = '0;
    expect_at(3, 1, 1, "R2");
    tick(4);
    // R1 magnitude equal to limit is no excursion
    duty = 8'sd14; tick(3 * H);
    duty = '0;
    expect_at(1, 1, 1, "R1");
    tick(3);
    // R1 negative excursion
    duty = -8'sd15;
    expect_at(H + 2, 1, 1, "R1");
    expect_at(H + 3, 0, 0, "R1");
    tick(H + 5);
    por_pulse();

    // R10 standby disables and holds DC count
    sb_drv = 1'b0; duty = 8'sd30;
    expect_at(2, 1, 1, "R10");
    expect_at(3, 0, 1, "R10");
    tick(3 * H);
    duty = '0; tick(2);
    sb_drv = 1'b1;
    expect_at(3, 1, 1, "R10");
    tick(5);

    // R7 thermal boundary and trip, R9 no alarm
    temp = 8'd150;
    expect_at(4, 1, 1, "R7");
    tick(5);
    temp = 8'd151;
    expect_at(2, 1, 1, "R7");
    expect_at(3, 0, 1, "R9");
    tick(4);
    // R8 hysteresis
    temp = 8'd140;
    expect_at(4, 0, 1, "R8");
    tick(5);
    temp = 8'd136;
    expect_at(4, 0, 1, "R8");
    tick(5);
    temp = 8'd135;
    expect_at(2, 0, 1, "R8");
    expect_at(3, 1, 1, "R8");
    tick(4);

    // R4 short latch
    short_det = 1'b1;
    expect_at(3, 1, 1, "R4");
    expect_at(4, 0, 0, "R4");
    tick(2);
    short_det = 1'b0;
    expect_at(10, 0, 0, "R4");
    tick(12);
    // R5 standby clears latch
    sb_drv = 1'b0;
    expect_at(3, 0, 0, "R5");
    expect_at(4, 0, 1, "R5");
    tick(5);
    sb_drv = 1'b1;
    expect_at(3, 1, 1, "R5");
    tick(4);
    // R5 clear has priority while standby low
    sb_drv = 1'b0; short_det = 1'b1;
    expect_at(4, 0, 1, "R5");
    expect_at(6, 0, 1, "R5");
    tick(7);
    short_det = 1'b0; tick(4);
    sb_drv = 1'b1;
    expect_at(3, 1, 1, "R5");
    tick(4);

    // R6 loopback recovery
    loop_mode = 1'b1;
    short_det = 1'b1;
    expect_at(4, 0, 0, "R6");
    expect_at(20, 1, 1, "R6");
    tick(2);
    short_det = 1'b0;
    tick(22);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule